// File: doc/BRIEF.md
# BCD Time and Calendar Counter Chain

This block keeps wall-clock time and a calendar in packed BCD. Seven registers are maintained: seconds, minutes, hours in 24-hour form, weekday, day of month, month and a two-digit year. A prescaler counts pulses of a 32.768 kHz enable input and produces one step of the chain per second. Every carry caused by that step, from seconds all the way to the year, resolves at the same clock edge. The day-of-month limit follows the length of the current month. February gains a 29th day whenever the two-digit year is a multiple of four, and 00 counts as one.

The top bit of the seconds register is a sticky oscillator-fail flag. It comes out of reset set, is raised again by a stop-detect input, and falls only when the host writes that bit as 0. A host write port can load any single field. Loading the seconds field also restarts the prescaler, so the first step after setting the time comes one full second later.

Top module: `rtc_cal_chain`

## Requirements
- R1: After reset the fields read seconds 0x80 (fail flag set, count 00), minutes 0x00, hours 0x00, weekday 0x00, date 0x01, month 0x01 and year 0x00.
- R2: The chain steps once for every PRESCALE_DIV pulses of `tick_32k`. The new field values are visible in the cycle after the clock edge that samples the final pulse.
- R3: Seconds and minutes each count 00 to 59 in BCD. When one wraps from 59 to 00 it advances the next field in the same step.
- R4: Hours count 00 to 23 in BCD. The wrap from 23 to 00 advances both the date and the weekday in the same step.
- R5: The weekday counts 0 to 6 in bits 2:0 and wraps from 6 to 0.
- R6: The date wraps to 01 and advances the month after 31 in months 01, 03, 05, 07, 08, 10 and 12, and after 30 in months 04, 06, 09 and 11.
- R7: In month 02 the date wraps after 29 when the BCD year is a multiple of four (00, 04, ..., 96) and after 28 otherwise.
- R8: The month counts 01 to 12 and wraps to 01, advancing the year. The year counts 00 to 99 in BCD and wraps to 00.
- R9: Seconds bit 7 is the fail flag. `osc_stop` high sets it at the next edge. A seconds write with data bit 7 = 0 clears it, a write with bit 7 = 1 leaves it unchanged, and counting never changes it.
- R10: While `wr_en` is high, `wr_sel` picks the field: 0 seconds, 1 minutes, 2 hours, 3 weekday, 4 date, 5 month, 6 year; 7 selects nothing. The value is stored with the unused high bits cleared: seconds/minutes bits 6:0, hours/date bits 5:0, month bits 4:0, weekday bits 2:0, year all 8 bits. A write cycle takes precedence over a step due in that same cycle, and that step is dropped.
- R11: A seconds write restarts the prescaler. The next step comes after a full PRESCALE_DIV further pulses, whatever pulses came before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_32k | input | 1 | One-cycle enable at the 32.768 kHz reference rate |
| osc_stop | input | 1 | Oscillator stop detected; sets the fail flag |
| wr_en | input | 1 | Host write strobe |
| wr_sel | input | 3 | Field select for the write |
| wr_data | input | 8 | Write value (BCD) |
| sec_o | output | 8 | Fail flag in bit 7, BCD seconds in bits 6:0 |
| min_o | output | 8 | BCD minutes |
| hour_o | output | 8 | BCD hours, 00-23 |
| wday_o | output | 8 | Weekday 0-6 |
| date_o | output | 8 | BCD day of month |
| month_o | output | 8 | BCD month |
| year_o | output | 8 | BCD two-digit year |

## Verification
The bench goes after the full carry cascade from 23:59:59 on the last day of the year with year 99. A chain that lets carries ripple over several cycles, or forgets the weekday, shows a half-updated date there. Month ends of 30 and 31 days and February in both kinds of year are covered, including year 10. A leap rule that tests the raw byte for divisibility by four would wrongly give that year a 29th of February. The bench also checks that the BCD units digit carries from 09 to 10 rather than to 0x0A. The fail flag is driven through set, hold across writes that keep bit 7 high, and clear. A write that lands on the same cycle as a due step is used to show that the step is dropped and that the write wins.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;

    typedef enum logic [2:0] {
        FS_SEC   = 3'd0,
        FS_MIN   = 3'd1,
        FS_HOUR  = 3'd2,
        FS_WDAY  = 3'd3,
        FS_DATE  = 3'd4,
        FS_MONTH = 3'd5,
        FS_YEAR  = 3'd6,
        FS_NONE  = 3'd7
    } field_sel_e;

    typedef struct packed {
        logic       fail;
        logic [7:0] sec;
        logic [7:0] min;
        logic [7:0] hour;
        logic [7:0] wday;
        logic [7:0] date;
        logic [7:0] month;
        logic [7:0] year;
    } cal_state_t;

    // Two-digit BCD year divisible by four: even tens with units 0/4/8,
    // odd tens with units 2/6.
    function automatic logic bcd_leap(input logic [7:0] yr);
        logic [3:0] u;
        u = yr[3:0];
        if (!yr[4]) return (u == 4'd0) || (u == 4'd4) || (u == 4'd8);
        return (u == 4'd2) || (u == 4'd6);
    endfunction

    function automatic logic [7:0] month_last_day(input logic [7:0] mon,
                                                  input logic       leap);
        case (mon)
            8'h02:                      return leap ? 8'h29 : 8'h28;
            8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
            default:                    return 8'h31;
        endcase
    endfunction

endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
    parameter int DIV = 32768
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_in,
    input  logic clear,
    output logic roll
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        roll  = tick_in && (cnt_q == LAST);
        cnt_d = cnt_q;
        if (clear)        cnt_d = '0;
        else if (roll)    cnt_d = '0;
        else if (tick_in) cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/rtc_bcd_step.sv
module rtc_bcd_step (
    input  logic [7:0] cur,
    input  logic [7:0] lo,
    input  logic [7:0] hi,
    input  logic       en,
    output logic [7:0] nxt,
    output logic       wrap
);
    always_comb begin
        wrap = en && (cur == hi);
        if (!en)                 nxt = cur;
        else if (cur == hi)      nxt = lo;
        else if (cur[3:0] == 4'd9) nxt = {cur[7:4] + 4'd1, 4'd0};
        else                     nxt = {cur[7:4], cur[3:0] + 4'd1};
    end
endmodule

// File: rtl/rtc_cal_chain.sv
module rtc_cal_chain
    import rtc_cal_pkg::*;
#(
    parameter int PRESCALE_DIV = 32768
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_32k,
    input  logic       osc_stop,
    input  logic       wr_en,
    input  logic [2:0] wr_sel,
    input  logic [7:0] wr_data,
    output logic [7:0] sec_o,
    output logic [7:0] min_o,
    output logic [7:0] hour_o,
    output logic [7:0] wday_o,
    output logic [7:0] date_o,
    output logic [7:0] month_o,
    output logic [7:0] year_o
);
    // chain order: seconds, minutes, hours, date, month, year
    localparam int NF = 6;
    localparam int IX_SEC = 0, IX_MIN = 1, IX_HOUR = 2,
                   IX_DATE = 3, IX_MON = 4, IX_YEAR = 5;

    cal_state_t st_d, st_q;

    logic          roll, step, sec_wr;
    logic [7:0]    cur_v [NF];
    logic [7:0]    lo_v  [NF];
    logic [7:0]    hi_v  [NF];
    logic [7:0]    nxt_v [NF];
    logic [NF-1:0] en_v, wrap_v;

    assign sec_wr = wr_en && (field_sel_e'(wr_sel) == FS_SEC);
    assign step   = roll && !wr_en;

    rtc_prescaler #(.DIV(PRESCALE_DIV)) u_presc (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_in (tick_32k),
        .clear   (sec_wr),
        .roll    (roll)
    );

    always_comb begin
        cur_v[IX_SEC]  = {1'b0, st_q.sec[6:0]}; lo_v[IX_SEC]  = 8'h00; hi_v[IX_SEC]  = 8'h59;
        cur_v[IX_MIN]  = st_q.min;               lo_v[IX_MIN]  = 8'h00; hi_v[IX_MIN]  = 8'h59;
        cur_v[IX_HOUR] = st_q.hour;              lo_v[IX_HOUR] = 8'h00; hi_v[IX_HOUR] = 8'h23;
        cur_v[IX_DATE] = st_q.date;              lo_v[IX_DATE] = 8'h01;
        hi_v[IX_DATE]  = month_last_day(st_q.month, bcd_leap(st_q.year));
        cur_v[IX_MON]  = st_q.month;             lo_v[IX_MON]  = 8'h01; hi_v[IX_MON]  = 8'h12;
        cur_v[IX_YEAR] = st_q.year;              lo_v[IX_YEAR] = 8'h00; hi_v[IX_YEAR] = 8'h99;
    end

    for (genvar g = 0; g < NF; g++) begin : g_field
        if (g == 0) begin : g_head
            assign en_v[g] = step;
        end else begin : g_link
            assign en_v[g] = wrap_v[g-1];
        end
        rtc_bcd_step u_step (
            .cur  (cur_v[g]),
            .lo   (lo_v[g]),
            .hi   (hi_v[g]),
            .en   (en_v[g]),
            .nxt  (nxt_v[g]),
            .wrap (wrap_v[g])
        );
    end

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            case (field_sel_e'(wr_sel))
                FS_SEC:   st_d.sec   = {1'b0, wr_data[6:0]};
                FS_MIN:   st_d.min   = {1'b0, wr_data[6:0]};
                FS_HOUR:  st_d.hour  = {2'b0, wr_data[5:0]};
                FS_WDAY:  st_d.wday  = {5'b0, wr_data[2:0]};
                FS_DATE:  st_d.date  = {2'b0, wr_data[5:0]};
                FS_MONTH: st_d.month = {3'b0, wr_data[4:0]};
                FS_YEAR:  st_d.year  = wr_data;
                default:  ;
            endcase
        end else begin
            st_d.sec   = nxt_v[IX_SEC];
            st_d.min   = nxt_v[IX_MIN];
            st_d.hour  = nxt_v[IX_HOUR];
            st_d.date  = nxt_v[IX_DATE];
            st_d.month = nxt_v[IX_MON];
            st_d.year  = nxt_v[IX_YEAR];
            if (wrap_v[IX_HOUR])
                st_d.wday = (st_q.wday[2:0] >= 3'd6) ? 8'h00
                                                     : {5'b0, st_q.wday[2:0] + 3'd1};
        end
        if (sec_wr && !wr_data[7]) st_d.fail = 1'b0;
        if (osc_stop)              st_d.fail = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.fail  <= 1'b1;
            st_q.date  <= 8'h01;
            st_q.month <= 8'h01;
        end else begin
            st_q <= st_d;
        end
    end

    assign sec_o   = {st_q.fail, st_q.sec[6:0]};
    assign min_o   = st_q.min;
    assign hour_o  = st_q.hour;
    assign wday_o  = st_q.wday;
    assign date_o  = st_q.date;
    assign month_o = st_q.month;
    assign year_o  = st_q.year;
endmodule

// File: rtl/rtc_cal_chain_chk.sv
module rtc_cal_chain_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       osc_stop,
    input logic       wr_en,
    input logic [2:0] wr_sel,
    input logic [7:0] wr_data,
    input logic [7:0] sec_o,
    input logic [7:0] min_o,
    input logic [7:0] hour_o,
    input logic [7:0] wday_o,
    input logic [7:0] date_o
);
    AST_FAIL_SET: assert property (@(posedge clk) disable iff (!rst_n)
        osc_stop |=> sec_o[7]);  // R9

    AST_FAIL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_o[7] && !(wr_en && wr_sel == 3'd0 && !wr_data[7])) |=> sec_o[7]);  // R9

    AST_MIN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && sec_o[6:0] != 7'h59) |=> $stable(min_o));  // R3

    AST_HOUR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && min_o != 8'h59) |=> $stable(hour_o));  // R3

    AST_DAY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && hour_o != 8'h23) |=> ($stable(wday_o) && $stable(date_o)));  // R4

    AST_MIN_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == 3'd1) |=> (min_o == {1'b0, $past(wr_data[6:0])}));  // R10
endmodule

bind rtc_cal_chain rtc_cal_chain_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .osc_stop (osc_stop),
    .wr_en    (wr_en),
    .wr_sel   (wr_sel),
    .wr_data  (wr_data),
    .sec_o    (sec_o),
    .min_o    (min_o),
    .hour_o   (hour_o),
    .wday_o   (wday_o),
    .date_o   (date_o)
);

// File: tb/rtc_cal_chain_test.sv
`timescale 1ns/1ps
module rtc_cal_chain_test;
    localparam int DIV = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_32k = 1'b0;
    logic       osc_stop = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] wr_sel = 3'd7;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] sec_o, min_o, hour_o, wday_o, date_o, month_o, year_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    rtc_cal_chain #(.PRESCALE_DIV(DIV)) uut (
        .clk(clk), .rst_n(rst_n), .tick_32k(tick_32k), .osc_stop(osc_stop),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .sec_o(sec_o), .min_o(min_o), .hour_o(hour_o), .wday_o(wday_o),
        .date_o(date_o), .month_o(month_o), .year_o(year_o)
    );

    task automatic chk(input string req, input string what,
                       input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %02h expected %02h", req, what, act, exp);
        end
    endtask

    task automatic pulse();
        @(negedge clk) tick_32k = 1'b1;
        @(negedge clk) tick_32k = 1'b0;
    endtask

    task automatic one_second();
        for (int i = 0; i < DIV; i++) pulse();
    endtask

    task automatic wr(input logic [2:0] sel, input logic [7:0] d);
        @(negedge clk) begin wr_en = 1'b1; wr_sel = sel; wr_data = d; end
        @(negedge clk) begin wr_en = 1'b0; wr_sel = 3'd7; end
    endtask

    task automatic set_all(input logic [7:0] yr, mo, dt, wd, hr, mi, se);
        wr(3'd6, yr); wr(3'd5, mo); wr(3'd4, dt); wr(3'd3, wd);
        wr(3'd2, hr); wr(3'd1, mi); wr(3'd0, se);
    endtask

    task automatic t_reset();
        chk("R1", "sec", sec_o, 8'h80);   chk("R1", "min", min_o, 8'h00);
        chk("R1", "hour", hour_o, 8'h00); chk("R1", "wday", wday_o, 8'h00);
        chk("R1", "date", date_o, 8'h01); chk("R1", "month", month_o, 8'h01);
        chk("R1", "year", year_o, 8'h00);
    endtask

    task automatic t_prescale();
        for (int i = 0; i < DIV - 1; i++) pulse();
        chk("R2", "sec before last pulse", sec_o, 8'h80);
        pulse();
        chk("R2", "sec after last pulse", sec_o, 8'h81);
        pulse(); pulse();
        wr(3'd0, 8'h10);
        for (int i = 0; i < DIV - 1; i++) pulse();
        chk("R11", "sec after restart, short", sec_o, 8'h10);
        pulse();
        chk("R11", "sec after restart, full", sec_o, 8'h11);
        for (int i = 0; i < 8; i++) one_second();
        chk("R3", "units carry 19", sec_o, 8'h19);
        one_second();
        chk("R3", "units carry 20", sec_o, 8'h20);
    endtask

    task automatic t_minute_carry();
        set_all(8'h05, 8'h06, 8'h07, 8'h02, 8'h05, 8'h59, 8'h59);
        one_second();
        chk("R3", "sec wrap", sec_o, 8'h00);
        chk("R3", "min wrap", min_o, 8'h00);
        chk("R3", "hour carry", hour_o, 8'h06);
        chk("R3", "date held", date_o, 8'h07);
    endtask

    task automatic t_day_carry();
        set_all(8'h05, 8'h03, 8'h15, 8'h06, 8'h23, 8'h59, 8'h59);
        one_second();
        chk("R4", "hour wrap", hour_o, 8'h00);
        chk("R4", "date advance", date_o, 8'h16);
        chk("R5", "wday 6->0", wday_o, 8'h00);
        set_all(8'h05, 8'h03, 8'h16, 8'h02, 8'h23, 8'h59, 8'h59);
        one_second();
        chk("R5", "wday 2->3", wday_o, 8'h03);
    endtask

    task automatic end_of_day(input logic [7:0] yr, mo, dt,
                              input logic [7:0] exp_mo, exp_dt,
                              input string req);
        set_all(yr, mo, dt, 8'h01, 8'h23, 8'h59, 8'h59);
        one_second();
        chk(req, "month", month_o, exp_mo);
        chk(req, "date", date_o, exp_dt);
    endtask

    task automatic t_month_len();
        end_of_day(8'h05, 8'h04, 8'h30, 8'h05, 8'h01, "R6");
        end_of_day(8'h05, 8'h01, 8'h31, 8'h02, 8'h01, "R6");
        end_of_day(8'h05, 8'h05, 8'h30, 8'h05, 8'h31, "R6");
        end_of_day(8'h05, 8'h11, 8'h30, 8'h12, 8'h01, "R6");
    endtask

    task automatic t_leap();
        end_of_day(8'h24, 8'h02, 8'h28, 8'h02, 8'h29, "R7");
        end_of_day(8'h24, 8'h02, 8'h29, 8'h03, 8'h01, "R7");
        end_of_day(8'h23, 8'h02, 8'h28, 8'h03, 8'h01, "R7");
        end_of_day(8'h00, 8'h02, 8'h28, 8'h02, 8'h29, "R7");
        end_of_day(8'h10, 8'h02, 8'h28, 8'h03, 8'h01, "R7");
        end_of_day(8'h12, 8'h02, 8'h28, 8'h02, 8'h29, "R7");
    endtask

    task automatic t_year();
        set_all(8'h99, 8'h12, 8'h31, 8'h04, 8'h23, 8'h59, 8'h59);
        one_second();
        chk("R8", "year 99->00", year_o, 8'h00);
        chk("R8", "month 12->01", month_o, 8'h01);
        chk("R8", "date", date_o, 8'h01);
        chk("R8", "sec", sec_o, 8'h00);
        set_all(8'h19, 8'h12, 8'h31, 8'h04, 8'h23, 8'h59, 8'h59);
        one_second();
        chk("R8", "year 19->20", year_o, 8'h20);
    endtask

    task automatic t_fail_flag();
        wr(3'd0, 8'h05);
        chk("R9", "cleared by write 0", sec_o, 8'h05);
        @(negedge clk) osc_stop = 1'b1;
        @(negedge clk) osc_stop = 1'b0;
        chk("R9", "set by stop", sec_o, 8'h85);
        wr(3'd0, 8'h87);
        chk("R9", "write 1 keeps flag", sec_o, 8'h87);
        one_second();
        chk("R9", "kept while counting", sec_o, 8'h88);
        wr(3'd0, 8'h07);
        chk("R9", "cleared again", sec_o, 8'h07);
    endtask

    task automatic t_write();
        wr(3'd3, 8'hF3); chk("R10", "wday mask", wday_o, 8'h03);
        wr(3'd2, 8'hC7); chk("R10", "hour mask", hour_o, 8'h07);
        wr(3'd5, 8'hE9); chk("R10", "month mask", month_o, 8'h09);
        wr(3'd4, 8'hC4); chk("R10", "date mask", date_o, 8'h04);
        wr(3'd1, 8'hC5); chk("R10", "min mask", min_o, 8'h45);
        wr(3'd7, 8'h33);
        chk("R10", "sel 7 min", min_o, 8'h45);
        chk("R10", "sel 7 year", year_o, 8'h20);
        wr(3'd0, 8'h20);
        for (int i = 0; i < DIV - 1; i++) pulse();
        @(negedge clk) begin tick_32k = 1'b1; wr_en = 1'b1; wr_sel = 3'd1; wr_data = 8'h30; end
        @(negedge clk) begin tick_32k = 1'b0; wr_en = 1'b0; wr_sel = 3'd7; end
        chk("R10", "step dropped", sec_o, 8'h20);
        chk("R10", "write won", min_o, 8'h30);
        one_second();
        chk("R10", "next step", sec_o, 8'h21);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_prescale();
        t_minute_carry();
        t_day_carry();
        t_month_len();
        t_leap();
        t_year();
        t_fail_flag();
        t_write();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule